// File: doc/BRIEF.md
# Machine Clock Source Selection Controller

This block decides which clock source drives the machine clock of the chip. There are three sources. One is the main oscillator divided by two. Another is the sub oscillator divided by four. The third is a PLL output at one of four multiplication rates. Software writes a main-select bit, a sub-select bit and a two-bit rate field. These bits are only requests. The block leaves its current source only when the event that suits the transition arrives:

- the PLL stabilization-done pulse,
- the main oscillator stabilization-done pulse,
- the PLL/main alignment pulse,
- the main/sub alignment pulse.

The block drives a mux select code and a rate code into an external glitch-free clock multiplexer. Two status bits report the source actually in use, and they lag the request bits until a switch completes. A hardware standby or watchdog-reset pulse forces the main-select request back to 1. The oscillators, the PLL and the multiplexer sit outside the block.

Top module: `mclk_source_ctrl`

## Requirements
- R1: After reset the mux select `src_sel` is 2'b00 (main). Both `pll_off` and `sub_off` are 1, both request bits `sel_main` and `sel_sub` are 1, and `rate_out` is 2'b00.
- R2: `src_sel` encodes main as 2'b00, PLL as 2'b01 and sub as 2'b10, and never takes 2'b11. `pll_off` is 0 exactly while the PLL is in use. `sub_off` is 0 exactly while the sub clock is in use.
- R3: The rate field is captured into `rate_out` only when a PLL source is entered. A rate write made while the PLL is running leaves `rate_out` unchanged.
- R4: When both request bits are 0, the sub clock is chosen in preference to the PLL.
- R5: From main, a request with `sel_main`=0 and `sel_sub`=1 enters a wait. The PLL becomes the source only in the cycle after a `pll_stable` pulse. Other event pulses are ignored during this wait.
- R6: While the PLL is in use, any of the following starts a return to main: `sel_main`=1, `sel_sub`=0, or a `standby` pulse. A `standby` pulse also sets `sel_main` to 1. Main becomes the source only in the cycle after a `pll_main_align` pulse.
- R7: From main, `sel_sub`=0 starts a switch to sub. The switch completes only in the cycle after a `main_sub_align` pulse.
- R8: From sub, `sel_sub`=1 starts a wait that completes only in the cycle after a `main_stable` pulse. The new source is then main if `sel_main` is 1, and otherwise the PLL at the requested rate.
- R9: A write that arrives while a switch is pending updates the request bits without cutting the switch short. The new request is acted upon after the switch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the request bits |
| wr_main | input | 1 | Main-select value to write (1 main, 0 PLL) |
| wr_sub | input | 1 | Sub-select value to write (0 requests sub) |
| wr_rate | input | 2 | PLL multiplication rate value to write |
| standby | input | 1 | Hardware standby or watchdog reset pulse |
| pll_stable | input | 1 | PLL stabilization-done pulse |
| main_stable | input | 1 | Main oscillator stabilization-done pulse |
| pll_main_align | input | 1 | PLL/main alignment pulse |
| main_sub_align | input | 1 | Main/sub alignment pulse |
| sel_main | output | 1 | Current main-select request |
| sel_sub | output | 1 | Current sub-select request |
| src_sel | output | 2 | Mux select code of the source in use |
| rate_out | output | 2 | PLL rate code in use |
| pll_off | output | 1 | 1 while the PLL is not the machine clock |
| sub_off | output | 1 | 1 while the sub clock is not the machine clock |

## Verification
Each switch is attacked by first sending the wrong event pulse during its wait and then the right one. A design that took any pulse as completion would change `src_sel` too early. Both request bits are cleared together, from main and from the PLL, to catch a design that lets the PLL win. A rate write is issued mid-PLL, which catches a design that passes the rate field straight through. A request is rewritten while a switch is pending. A design that aborted the switch, or that lost the later request, would land on the wrong final source.

// File: rtl/mclk_source_ctrl.sv
module mclk_source_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_main,
  input  logic       wr_sub,
  input  logic [1:0] wr_rate,
  input  logic       standby,
  input  logic       pll_stable,
  input  logic       main_stable,
  input  logic       pll_main_align,
  input  logic       main_sub_align,
  output logic       sel_main,
  output logic       sel_sub,
  output logic [1:0] src_sel,
  output logic [1:0] rate_out,
  output logic       pll_off,
  output logic       sub_off
);

  typedef enum logic [2:0] {
    ON_MAIN, MAIN_TO_PLL, ON_PLL, PLL_TO_MAIN, MAIN_TO_SUB, ON_SUB, SUB_TO_X
  } st_t;

  localparam logic [1:0] SRC_MAIN = 2'b00;
  localparam logic [1:0] SRC_PLL  = 2'b01;
  localparam logic [1:0] SRC_SUB  = 2'b10;

  st_t        st, st_nx;
  logic [1:0] req_rate;
  logic [1:0] rate_q;
  logic       load_rate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_main <= 1'b1;
      sel_sub  <= 1'b1;
      req_rate <= 2'b00;
    end else begin
      if (wr_en) begin
        sel_main <= wr_main;
        sel_sub  <= wr_sub;
        req_rate <= wr_rate;
      end
      if (standby) sel_main <= 1'b1;
    end
  end

  always_comb begin
    st_nx     = st;
    load_rate = 1'b0;
    unique case (st)
      ON_MAIN:
        if (!sel_sub)       st_nx = MAIN_TO_SUB;
        else if (!sel_main) st_nx = MAIN_TO_PLL;
      MAIN_TO_PLL:
        if (pll_stable) begin
          st_nx     = ON_PLL;
          load_rate = 1'b1;
        end
      ON_PLL:
        if (sel_main || !sel_sub || standby) st_nx = PLL_TO_MAIN;
      PLL_TO_MAIN:
        if (pll_main_align) st_nx = ON_MAIN;
      MAIN_TO_SUB:
        if (main_sub_align) st_nx = ON_SUB;
      ON_SUB:
        if (sel_sub) st_nx = SUB_TO_X;
      SUB_TO_X:
        if (main_stable) begin
          if (sel_main) st_nx = ON_MAIN;
          else begin
            st_nx     = ON_PLL;
            load_rate = 1'b1;
          end
        end
      default: st_nx = ON_MAIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ON_MAIN;
      rate_q <= 2'b00;
    end else begin
      st <= st_nx;
      if (load_rate) rate_q <= req_rate;
    end
  end

  always_comb begin
    unique case (st)
      ON_PLL, PLL_TO_MAIN: src_sel = SRC_PLL;
      ON_SUB, SUB_TO_X:    src_sel = SRC_SUB;
      default:             src_sel = SRC_MAIN;
    endcase
  end

  assign rate_out = rate_q;
  assign pll_off  = (src_sel != SRC_PLL);
  assign sub_off  = (src_sel != SRC_SUB);

  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel != 2'b11); // R2
  AST_PLL_ENTRY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_off) |-> ($past(pll_stable) || $past(main_stable))); // R5
  AST_PLL_EXIT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_off) |-> $past(pll_main_align)); // R6
  AST_SUB_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sub_off) |-> $past(main_sub_align)); // R7
  AST_SUB_EXIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_off) |-> $past(main_stable)); // R8
  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_off && $past(!pll_off)) |-> $stable(rate_out)); // R3
  AST_STANDBY_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> sel_main); // R6

endmodule

// File: tb/test_mclk_source_ctrl.sv
module test_mclk_source_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_main = 1'b0, wr_sub = 1'b0;
  logic [1:0] wr_rate = 2'b00;
  logic standby = 1'b0, pll_stable = 1'b0, main_stable = 1'b0;
  logic pll_main_align = 1'b0, main_sub_align = 1'b0;
  logic sel_main, sel_sub, pll_off, sub_off;
  logic [1:0] src_sel, rate_out;

  always #5 clk = ~clk;

  mclk_source_ctrl i_mclk_source_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_main(wr_main), .wr_sub(wr_sub),
    .wr_rate(wr_rate), .standby(standby), .pll_stable(pll_stable),
    .main_stable(main_stable), .pll_main_align(pll_main_align),
    .main_sub_align(main_sub_align), .sel_main(sel_main), .sel_sub(sel_sub),
    .src_sel(src_sel), .rate_out(rate_out), .pll_off(pll_off), .sub_off(sub_off));

  typedef struct {
    string      tag;
    logic [1:0] src;
    logic [1:0] rate;
    logic       m;
    logic       s;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  localparam logic [1:0] MAIN = 2'b00, PLL = 2'b01, SUB = 2'b10;
  localparam int EV_NONE = 0, EV_PLLST = 1, EV_MAINST = 2, EV_PMA = 3, EV_MSA = 4, EV_SBY = 5;

  task automatic step(input string tag, input bit we, input bit m, input bit s,
                      input logic [1:0] r, input int ev,
                      input logic [1:0] e_src, input logic [1:0] e_rate,
                      input bit e_m, input bit e_s);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_main = m; wr_sub = s; wr_rate = r;
    pll_stable = (ev == EV_PLLST);
    main_stable = (ev == EV_MAINST);
    pll_main_align = (ev == EV_PMA);
    main_sub_align = (ev == EV_MSA);
    standby = (ev == EV_SBY);
    @(posedge clk);
    #1;
    e.tag = tag; e.src = e_src; e.rate = e_rate; e.m = e_m; e.s = e_s;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag, input int ev, input logic [1:0] e_src,
                      input logic [1:0] e_rate, input bit e_m, input bit e_s);
    step(tag, 1'b0, 1'b0, 1'b0, 2'b00, ev, e_src, e_rate, e_m, e_s);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (src_sel !== e.src || rate_out !== e.rate || pll_off !== (e.src != PLL) ||
            sub_off !== (e.src != SUB) || sel_main !== e.m || sel_sub !== e.s) begin
          n_bad++;
          $display("FAIL %s: src=%b rate=%b pll_off=%b sub_off=%b sel=%b%b expected src=%b rate=%b pll_off=%b sub_off=%b sel=%b%b",
                   e.tag, src_sel, rate_out, pll_off, sub_off, sel_main, sel_sub,
                   e.src, e.rate, e.src != PLL, e.src != SUB, e.m, e.s);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state", EV_NONE, MAIN, 2'b00, 1, 1);
    // main -> PLL rate 01
    step("R5 write pll req", 1, 0, 1, 2'b01, EV_NONE, MAIN, 2'b00, 0, 1);
    idle("R5 waiting", EV_NONE, MAIN, 2'b00, 0, 1);
    idle("R5 wrong event ignored", EV_MAINST, MAIN, 2'b00, 0, 1);
    idle("R5 pll stable", EV_PLLST, PLL, 2'b01, 0, 1);
    step("R3 rate write in pll", 1, 0, 1, 2'b11, EV_NONE, PLL, 2'b01, 0, 1);
    idle("R3 rate still held", EV_NONE, PLL, 2'b01, 0, 1);
    // PLL -> main by write
    step("R6 write main req", 1, 1, 1, 2'b11, EV_NONE, PLL, 2'b01, 1, 1);
    idle("R6 waiting align", EV_NONE, PLL, 2'b01, 1, 1);
    idle("R6 wrong event ignored", EV_PLLST, PLL, 2'b01, 1, 1);
    idle("R6 align to main", EV_PMA, MAIN, 2'b01, 1, 1);
    // main -> PLL rate 10, then standby
    step("R5 write pll rate10", 1, 0, 1, 2'b10, EV_NONE, MAIN, 2'b01, 0, 1);
    idle("R5 waiting", EV_NONE, MAIN, 2'b01, 0, 1);
    idle("R5 pll stable rate10", EV_PLLST, PLL, 2'b10, 0, 1);
    idle("R6 standby forces main req", EV_SBY, PLL, 2'b10, 1, 1);
    idle("R6 standby waits align", EV_MSA, PLL, 2'b10, 1, 1);
    idle("R6 standby align", EV_PMA, MAIN, 2'b10, 1, 1);
    // main -> sub
    step("R7 write sub req", 1, 1, 0, 2'b00, EV_NONE, MAIN, 2'b10, 1, 0);
    idle("R7 waiting", EV_NONE, MAIN, 2'b10, 1, 0);
    idle("R7 wrong event ignored", EV_MAINST, MAIN, 2'b10, 1, 0);
    idle("R7 align to sub", EV_MSA, SUB, 2'b10, 1, 0);
    // sub -> PLL rate 00
    step("R8 write pll while on sub", 1, 0, 0, 2'b00, EV_NONE, SUB, 2'b10, 0, 0);
    idle("R4 both zero stays sub", EV_NONE, SUB, 2'b10, 0, 0);
    step("R8 release sub", 1, 0, 1, 2'b00, EV_NONE, SUB, 2'b10, 0, 1);
    idle("R8 waiting", EV_NONE, SUB, 2'b10, 0, 1);
    idle("R8 wrong event ignored", EV_PMA, SUB, 2'b10, 0, 1);
    idle("R8 stable to pll", EV_MAINST, PLL, 2'b00, 0, 1);
    // PLL with both zero -> main -> sub
    step("R4 both zero from pll", 1, 0, 0, 2'b11, EV_NONE, PLL, 2'b00, 0, 0);
    idle("R4 leaving pll", EV_NONE, PLL, 2'b00, 0, 0);
    idle("R4 align to main", EV_PMA, MAIN, 2'b00, 0, 0);
    idle("R4 heading to sub", EV_NONE, MAIN, 2'b00, 0, 0);
    idle("R4 pll event ignored", EV_PLLST, MAIN, 2'b00, 0, 0);
    idle("R4 align to sub", EV_MSA, SUB, 2'b00, 0, 0);
    // sub -> main
    step("R8 request main", 1, 1, 1, 2'b00, EV_NONE, SUB, 2'b00, 1, 1);
    idle("R8 waiting", EV_NONE, SUB, 2'b00, 1, 1);
    idle("R8 stable to main", EV_MAINST, MAIN, 2'b00, 1, 1);
    // both zero from main
    step("R4 both zero from main", 1, 0, 0, 2'b01, EV_NONE, MAIN, 2'b00, 0, 0);
    idle("R4 waiting", EV_NONE, MAIN, 2'b00, 0, 0);
    idle("R4 pll stable ignored", EV_PLLST, MAIN, 2'b00, 0, 0);
    idle("R4 sub chosen", EV_MSA, SUB, 2'b00, 0, 0);
    // pending write
    step("R9 request main", 1, 1, 1, 2'b00, EV_NONE, SUB, 2'b00, 1, 1);
    idle("R9 waiting", EV_NONE, SUB, 2'b00, 1, 1);
    step("R9 write sub during wait", 1, 1, 0, 2'b00, EV_NONE, SUB, 2'b00, 1, 0);
    idle("R9 wait not cut", EV_NONE, SUB, 2'b00, 1, 0);
    idle("R9 completes to main", EV_MAINST, MAIN, 2'b00, 1, 0);
    idle("R9 re-check toward sub", EV_NONE, MAIN, 2'b00, 1, 0);
    idle("R9 back on sub", EV_MSA, SUB, 2'b00, 1, 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule